// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block runs on a system clock and connects a valid/ready request port to an external asynchronous static RAM of 128K words by 16 bits. The RAM has an active-low chip select, one active-low select for each byte lane, an active-low write strobe and an active-low output enable. Each request carries a direction, a 17-bit word address, 16 bits of write data and a 2-bit lane mask. The controller sequences the RAM pins through registered outputs. The length of each phase is a whole number of clock cycles, worked out at elaboration from nanosecond parameters and the clock period.

Writes are controlled by the strobe. The strobe goes low one cycle before the chip and lane selects. It then overlaps them for the programmed pulse length, and the data bus is held for one more cycle. Reads hold the chip select and output enable low for the read-cycle count. Read data is registered on the last read cycle and returned with a one-cycle valid pulse. Lanes that are not selected return zero.

The controller drives the data bus only while the RAM output enable is high. After a read it waits a turnaround count before it drives write data. A standby input, taken only when the controller is idle, parks the RAM deselected and blocks new requests.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After synchronous reset, sram_cs_n, sram_we_n and sram_oe_n are 1, sram_bc_n is 2'b11, sram_dq_oe is 0, rsp_valid is 0 and req_ready is 1.
- R2: A write stores req_wdata[7:0] in the lower lane when mask bit 0 is 1, through sram_bc_n[0]. It stores req_wdata[15:8] in the upper lane when mask bit 1 is 1, through sram_bc_n[1]. Lanes whose mask bit is 0 keep their old content. The write is made at req_addr.
- R3: In a write, sram_we_n is already low in the cycle before sram_cs_n and the selected sram_bc_n go low.
- R4: The write overlap lasts exactly max(ceil(T_WP/P), ceil(T_DS/P), ceil(T_WC/P)-1) cycles: chip select, write strobe and at least one lane select are all low together. With the defaults this is 3 cycles.
- R5: During the whole write overlap, sram_addr and sram_dq_o are stable and sram_dq_oe is 1.
- R6: A read holds sram_cs_n and sram_oe_n low and sram_we_n high for exactly ceil(T_RC/P) cycles, which is 3 with the defaults. rsp_valid is then high for exactly one cycle, and rsp_rdata carries the selected lanes, with unselected lanes reading 0.
- R7: sram_dq_oe is never 1 while sram_oe_n is 0.
- R8: After sram_oe_n rises at the end of a read, sram_dq_oe stays 0 for at least ceil(T_TURN/P) cycles, which is 1 with the defaults.
- R9: req_ready is 1 only when the controller is idle and standby is 0. A request is taken on a clock edge where req_valid and req_ready are both 1, and req_ready is 0 in the cycle after that.
- R10: When standby is 1 while the controller is idle, req_ready is 0, the RAM pins stay inactive and a pending request is not taken. The request is taken once standby returns to 0.
- R11: A write with mask 2'b00 changes no memory word and produces no write overlap. A read with mask 2'b00 returns 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| standby | input | 1 | Park the RAM deselected when idle |
| sram_addr | output | 17 | RAM address |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_bc_n | output | 2 | RAM lane selects, bit 0 lower, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_o | output | 16 | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Enable of the data bus driver |
| sram_dq_i | input | 16 | Data returned by the RAM |

## Verification
The bench goes after partial-lane writes, where a design that decodes the mask wrongly corrupts the neighbouring byte. It also tries an all-zero mask: a faulty design then writes a lane, or returns stale bus data. A read followed at once by a write checks the turnaround; a design that skips the wait drives the bus while the RAM may still be driving it. A phase counter that is off by one shows up as a write overlap or read window of the wrong length. The bench also checks that the strobe leads the selects, because a design that lowers them together can open a window where the RAM briefly drives the bus. Standby is raised while a request is pending, which shows whether the controller leaks the request onto the pins.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STBY,
    ST_WTURN,
    ST_WSET,
    ST_WPULSE,
    ST_WHOLD,
    ST_READ
  } ctl_state_t;

  // ceiling of num/den for positive operands
  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R4 / R6: a phase that was loaded with a nonzero count is not done a cycle later
  assert_phase_len_R4: assert property (@(posedge clk) disable iff (rst)
    (load && load_val != '0) |=> !zero);

endmodule

// File: rtl/sram_lane_turn.sv
module sram_lane_turn #(
  parameter int TURN_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic oe_n,
  output logic ok
);

  localparam int TW = $clog2(TURN_CYC + 1) + 1;

  logic [TW-1:0] quiet;

  always_ff @(posedge clk) begin
    if (rst)                            quiet <= TW'(TURN_CYC);
    else if (!oe_n)                     quiet <= '0;
    else if (quiet < TW'(TURN_CYC))     quiet <= quiet + 1'b1;
  end

  assign ok = (quiet >= TW'(TURN_CYC));

  // R8: the cycle after the RAM drove its outputs, the bus may not be turned yet
  assert_turn_gap_R8: assert property (@(posedge clk) disable iff (rst)
    !oe_n |=> !ok);

endmodule

// File: rtl/sram_lane_rdcap.sv
module sram_lane_rdcap #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cap,
  input  logic [LANES-1:0]        lane_en,
  input  logic [LANES*LANE_W-1:0] din,
  output logic                    valid,
  output logic [LANES*LANE_W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (rst) valid <= 1'b0;
    else     valid <= cap;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        dout[g*LANE_W +: LANE_W] <= '0;
      else if (cap)
        dout[g*LANE_W +: LANE_W] <= lane_en[g] ? din[g*LANE_W +: LANE_W] : '0;
    end
  end

  // R6: read data is flagged for a single cycle
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 16,
  parameter int LANE_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_RC_NS       = 55,
  parameter int T_WC_NS       = 55,
  parameter int T_WP_NS       = 45,
  parameter int T_DS_NS       = 25,
  parameter int T_TURN_NS     = 20
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic [DATA_W/LANE_W-1:0]   req_be,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_rdata,
  input  logic                       standby,
  output logic [ADDR_W-1:0]          sram_addr,
  output logic                       sram_cs_n,
  output logic [DATA_W/LANE_W-1:0]   sram_bc_n,
  output logic                       sram_we_n,
  output logic                       sram_oe_n,
  output logic [DATA_W-1:0]          sram_dq_o,
  output logic                       sram_dq_oe,
  input  logic [DATA_W-1:0]          sram_dq_i
);

  localparam int LANES    = DATA_W / LANE_W;
  localparam int RD_CYC   = imax(cdiv(T_RC_NS, CLK_PERIOD_NS), 1);
  localparam int WR_CYC   = imax(imax(cdiv(T_WP_NS, CLK_PERIOD_NS), cdiv(T_DS_NS, CLK_PERIOD_NS)),
                                 imax(cdiv(T_WC_NS, CLK_PERIOD_NS) - 1, 1));
  localparam int TURN_CYC = imax(cdiv(T_TURN_NS, CLK_PERIOD_NS), 1);
  localparam int CNT_W    = $clog2(imax(RD_CYC, WR_CYC) + 1);

  ctl_state_t          state, state_nxt;
  logic [ADDR_W-1:0]   op_addr, nxt_addr;
  logic [DATA_W-1:0]   op_data, nxt_data;
  logic [LANES-1:0]    op_be,   nxt_be;
  logic                accept, t_load, t_zero, turn_ok, cap;
  logic [CNT_W-1:0]    t_val;

  assign req_ready = (state == ST_IDLE) && !standby;
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (standby)        state_nxt = ST_STBY;
        else if (req_valid) state_nxt = req_write ? (turn_ok ? ST_WSET : ST_WTURN) : ST_READ;
      end
      ST_STBY:   if (!standby) state_nxt = ST_IDLE;
      ST_WTURN:  if (turn_ok)  state_nxt = ST_WSET;
      ST_WSET:                 state_nxt = ST_WPULSE;
      ST_WPULSE: if (t_zero)   state_nxt = ST_WHOLD;
      ST_WHOLD:                state_nxt = ST_IDLE;
      ST_READ:   if (t_zero)   state_nxt = ST_IDLE;
      default:                 state_nxt = ST_IDLE;
    endcase
  end

  assign t_load = (state_nxt != state) && (state_nxt == ST_WPULSE || state_nxt == ST_READ);
  assign t_val  = (state_nxt == ST_READ) ? CNT_W'(RD_CYC - 1) : CNT_W'(WR_CYC - 1);
  assign cap    = (state == ST_READ) && t_zero;

  assign nxt_addr = accept ? req_addr  : op_addr;
  assign nxt_data = accept ? req_wdata : op_data;
  assign nxt_be   = accept ? req_be    : op_be;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      op_addr <= '0;
      op_data <= '0;
      op_be   <= '0;
    end else begin
      state   <= state_nxt;
      op_addr <= nxt_addr;
      op_data <= nxt_data;
      op_be   <= nxt_be;
    end
  end

  // RAM pins are registered copies of what the next state calls for
  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr  <= '0;
      sram_dq_o  <= '0;
      sram_cs_n  <= 1'b1;
      sram_bc_n  <= '1;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_dq_oe <= 1'b0;
    end else begin
      sram_addr  <= nxt_addr;
      sram_dq_o  <= nxt_data;
      sram_cs_n  <= 1'b1;
      sram_bc_n  <= '1;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_dq_oe <= 1'b0;
      unique case (state_nxt)
        ST_WSET: begin
          sram_we_n  <= 1'b0;
          sram_dq_oe <= 1'b1;
        end
        ST_WPULSE: begin
          sram_we_n  <= 1'b0;
          sram_cs_n  <= 1'b0;
          sram_bc_n  <= ~nxt_be;
          sram_dq_oe <= 1'b1;
        end
        ST_WHOLD: sram_dq_oe <= 1'b1;
        ST_READ: begin
          sram_cs_n <= 1'b0;
          sram_oe_n <= 1'b0;
          sram_bc_n <= ~nxt_be;
        end
        default: ;
      endcase
    end
  end

  sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  sram_lane_turn #(.TURN_CYC(TURN_CYC)) u_turn (
    .clk(clk), .rst(rst), .oe_n(sram_oe_n), .ok(turn_ok)
  );

  sram_lane_rdcap #(.LANES(LANES), .LANE_W(LANE_W)) u_rdcap (
    .clk(clk), .rst(rst), .cap(cap), .lane_en(op_be), .din(sram_dq_i),
    .valid(rsp_valid), .dout(rsp_rdata)
  );

  // R3: the strobe is low already when the chip select falls in a write
  assert_strobe_first_R3: assert property (@(posedge clk) disable iff (rst)
    (!sram_cs_n && !sram_we_n && $fell(sram_cs_n)) |-> $past(!sram_we_n));

  // R5: address and data hold still across the write overlap
  assert_write_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!sram_cs_n && !sram_we_n && $past(!sram_cs_n && !sram_we_n))
      |-> ($stable(sram_addr) && $stable(sram_dq_o) && sram_dq_oe));

  // R7: the controller never drives while the RAM output is enabled
  assert_bus_excl_R7: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> sram_oe_n);

  // R9: a taken request makes the port busy
  assert_busy_after_take_R9: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);

  // R10: parked RAM sees only inactive controls
  assert_standby_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STBY) |-> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe));

endmodule

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;

  localparam int WR_EXP   = 3;
  localparam int RD_EXP   = 3;
  localparam int TURN_EXP = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, standby = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] sram_addr;
  logic        sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [1:0]  sram_bc_n;
  logic [15:0] sram_dq_o, sram_dq_i;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sram_lane_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .standby(standby),
    .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_bc_n(sram_bc_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq_o(sram_dq_o),
    .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] midx(input logic [16:0] a);
    return {a[16], a[6:0]};
  endfunction

  function automatic logic [15:0] init_word(input int i);
    return {i[7:0], ~i[7:0]};
  endfunction

  // behavioural RAM with a small backing store and bus monitor
  logic [15:0] mem [0:255];
  logic        wr_act, rd_act, prev_wr = 0, prev_rd = 0, prev_we_n = 1, prev_dq_oe = 0;
  int          wlen = 0, rlen = 0, quiet = 1000, wr_events = 0, turn_seen = 0;
  logic [16:0] wr_addr_seen = '0, last_wr_addr = '0;
  logic [15:0] wdat = '0;
  logic [1:0]  wlanes = '0;

  always_comb begin
    sram_dq_i = 16'h5AC3;
    if (!sram_cs_n && !sram_oe_n && sram_we_n) begin
      if (!sram_bc_n[0]) sram_dq_i[7:0]  = mem[midx(sram_addr)][7:0];
      if (!sram_bc_n[1]) sram_dq_i[15:8] = mem[midx(sram_addr)][15:8];
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] = init_word(i);
    end else begin
      wr_act = !sram_cs_n && !sram_we_n && (sram_bc_n != 2'b11);
      rd_act = !sram_cs_n && !sram_oe_n && sram_we_n;
      if (wr_act && !prev_wr) begin
        check(!prev_we_n, "R3 strobe before selects", {31'd0, prev_we_n}, 32'd0);
        check(sram_dq_oe, "R5 bus driven in write", {31'd0, sram_dq_oe}, 32'd1);
        wlen = 1; wr_addr_seen = sram_addr; wdat = sram_dq_o; wlanes = ~sram_bc_n;
      end else if (wr_act) begin
        wlen++;
        check(sram_addr == wr_addr_seen && sram_dq_o == wdat && sram_dq_oe,
              "R5 write hold", {15'd0, sram_addr}, {15'd0, wr_addr_seen});
      end
      if (!wr_act && prev_wr) begin
        check(wlen == WR_EXP, "R4 write overlap length", wlen, WR_EXP);
        if (wlanes[0]) mem[midx(wr_addr_seen)][7:0]  = wdat[7:0];
        if (wlanes[1]) mem[midx(wr_addr_seen)][15:8] = wdat[15:8];
        wr_events++;
        last_wr_addr = wr_addr_seen;
      end
      if (rd_act && !prev_rd) rlen = 1;
      else if (rd_act) rlen++;
      if (!rd_act && prev_rd) check(rlen == RD_EXP, "R6 read window length", rlen, RD_EXP);
      if (sram_dq_oe && !sram_oe_n) check(1'b0, "R7 bus driven during read", 32'd1, 32'd0);
      if (sram_dq_oe && !prev_dq_oe) begin
        check(quiet >= TURN_EXP, "R8 turnaround", quiet, TURN_EXP);
        if (quiet < 1000) turn_seen++;
      end
      if (!sram_oe_n) quiet = 0;
      else if (quiet < 1000) quiet++;
      prev_wr = wr_act; prev_rd = rd_act; prev_we_n = sram_we_n; prev_dq_oe = sram_dq_oe;
    end
  end

  task automatic send(input bit w, input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    for (int i = 0; i < 100 && !req_ready; i++) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && !req_ready; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
    send(1'b1, a, d, be);
    wait_idle();
    @(negedge clk);
    if (be != 2'b00) check(last_wr_addr == a, "R2 write address", {15'd0, last_wr_addr}, {15'd0, a});
  endtask

  task automatic do_read(input logic [16:0] a, input logic [1:0] be, input logic [15:0] exp, input string tag);
    send(1'b0, a, 16'h0, be);
    for (int i = 0; i < 100 && !rsp_valid; i++) @(negedge clk);
    check(rsp_valid && rsp_rdata == exp, tag, {16'd0, rsp_rdata}, {16'd0, exp});
    @(negedge clk);
    check(!rsp_valid, "R6 valid is one cycle", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_reset();
    check(sram_cs_n && sram_we_n && sram_oe_n && sram_bc_n == 2'b11 && !sram_dq_oe,
          "R1 pins after reset", {27'd0, sram_cs_n, sram_we_n, sram_oe_n, sram_bc_n}, 32'h1F);
    check(!rsp_valid && req_ready, "R1 handshake after reset", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  task automatic t_write_full();
    do_write(17'h00012, 16'hA1B2, 2'b11);
    check(mem[midx(17'h00012)] == 16'hA1B2, "R2 full write", mem[midx(17'h00012)], 16'hA1B2);
  endtask

  task automatic t_write_lanes();
    logic [15:0] v;
    v = init_word(int'(midx(17'h00034)));
    do_write(17'h00034, 16'h1234, 2'b01);
    check(mem[midx(17'h00034)] == {v[15:8], 8'h34}, "R2 lower lane only",
          mem[midx(17'h00034)], {v[15:8], 8'h34});
    do_write(17'h00034, 16'h5678, 2'b10);
    check(mem[midx(17'h00034)] == 16'h5634, "R2 upper lane only", mem[midx(17'h00034)], 16'h5634);
  endtask

  task automatic t_zero_mask();
    int ev;
    logic [15:0] v;
    ev = wr_events;
    v  = mem[midx(17'h00040)];
    do_write(17'h00040, 16'hFFFF, 2'b00);
    check(mem[midx(17'h00040)] == v, "R11 empty mask write", mem[midx(17'h00040)], v);
    check(wr_events == ev, "R11 no write overlap", wr_events, ev);
    do_read(17'h00040, 2'b00, 16'h0000, "R11 empty mask read");
  endtask

  task automatic t_read_lanes();
    do_read(17'h00012, 2'b11, 16'hA1B2, "R6 full read");
    do_read(17'h00012, 2'b01, 16'h00B2, "R6 lower lane read");
    do_read(17'h00012, 2'b10, 16'hA100, "R6 upper lane read");
  endtask

  task automatic t_top_addr();
    do_write(17'h1FFFF, 16'h0F0F, 2'b11);
    do_read(17'h1FFFF, 2'b11, 16'h0F0F, "R2 highest address read back");
  endtask

  task automatic t_turn();
    int ts;
    ts = turn_seen;
    send(1'b0, 17'h00012, 16'h0, 2'b11);
    send(1'b1, 17'h00050, 16'hC0DE, 2'b11);
    wait_idle();
    @(negedge clk);
    check(turn_seen == ts + 1, "R8 read then write turnaround seen", turn_seen, ts + 1);
    check(mem[midx(17'h00050)] == 16'hC0DE, "R8 write after read", mem[midx(17'h00050)], 16'hC0DE);
  endtask

  task automatic t_busy();
    send(1'b1, 17'h00060, 16'h7777, 2'b11);
    check(!req_ready, "R9 busy after take", {31'd0, req_ready}, 32'd0);
    wait_idle();
    check(req_ready, "R9 ready once idle", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_standby();
    @(negedge clk);
    standby = 1'b1;
    @(negedge clk);
    check(!req_ready && sram_cs_n, "R10 standby parks", {30'd0, req_ready, sram_cs_n}, 32'd1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00050; req_be = 2'b11;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!req_ready && sram_cs_n && sram_oe_n && sram_we_n, "R10 request held off",
            {29'd0, req_ready, sram_cs_n, sram_oe_n}, 32'd3);
    end
    standby = 1'b0;
    for (int i = 0; i < 100 && !req_ready; i++) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 100 && !rsp_valid; i++) @(negedge clk);
    check(rsp_valid && rsp_rdata == 16'hC0DE, "R10 request taken after standby",
          {16'd0, rsp_rdata}, 32'hC0DE);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_full();
    t_write_lanes();
    t_zero_mask();
    t_read_lanes();
    t_top_addr();
    t_turn();
    t_busy();
    t_standby();
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule